// File: doc/BRIEF.md
# Dual-Strobe Synchronous Burst SRAM

A synchronous static memory model intended as the data store of a processor's secondary cache. All control inputs are captured on the rising clock edge. A burst may be opened by either of two start strobes. One comes from the processor side and the other from the cache controller side. Once a burst is open, an advance input steps a two-bit burst counter through the low address bits. Leaving advance inactive suspends the burst, so the same word is accessed again, and this is how wait states are inserted.

Each data word is nine bits wide and is written through two byte-lane write enables. A burst opened by the processor strobe is always a read, whatever the write enables say. Only the controller strobe can open a write burst. Read data flows through combinationally from the registered burst address. The read bus drive is gated by an asynchronous output enable, and no clock edge lies in that path.

Top module: `burst_sram`

## Requirements
- R1: After reset the memory is deselected: no access takes place and `dq_oe` is 0 until a burst is started.
- R2: With `ce_n` high, a low on either `cpu_ads_n` or `ctl_ads_n` deselects the memory on that edge. While deselected, advance and suspend cycles write nothing and leave `dq_oe` at 0, until a new start.
- R3: With `ce_n` low and `cpu_ads_n` low, `addr` is latched and a read access begins. `wen_n` and `ctl_ads_n` have no effect, and no word is written.
- R4: With `ce_n` low, `cpu_ads_n` high and `ctl_ads_n` low, `addr` is latched. The access is a write if either `wen_n` bit is 0, and a read if both are 1.
- R5: With both strobes high and `adv_n` low in an open burst, addr[1:0] steps by one with wrap 3 to 0, and the upper address bits stay fixed. `ce_n` is ignored. The access is a read or a write according to `wen_n`.
- R6: With both strobes high and `adv_n` high in an open burst, the address is unchanged and the access repeats at the current word (a wait state).
- R7: `wen_n[0]` low writes bits [4:0] of the word, and `wen_n[1]` low writes bits [8:5]. A lane whose enable is high keeps its old contents.
- R8: `dq_oe` is 1 exactly when the access selected at the last edge is a read and `oe_n` is 0. `oe_n` acts without a clock edge. `dq_out` shows the word at the registered burst address.
- R9: Write data is taken from `dq_in` on the same edge as the command. It goes to the address that edge selects: the latched address on a start, the stepped address on an advance, the current address on a suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cpu_ads_n | input | 1 | Processor-side burst start strobe, active low |
| ctl_ads_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| wen_n | input | 2 | Lane write enables, active low (bit 0 lower lane) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Read bus drive enable |

## Verification
The bench builds the block with its default values: a 6-bit address, nine-bit words and a 5/4 lane split. With these values a single four-word group holds a full burst, so the counter wrap from word 3 back to word 0 appears within one short sequence. The lane split is asymmetric, so a partial write shows which bits each enable covers. The 64-word store is small enough that the bench can predict every read from the words it wrote.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_START_RD,
    CMD_START_CTL,
    CMD_STEP,
    CMD_HOLD
  } cmd_e;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
(
  input  logic ce_n,
  input  logic cpu_ads_n,
  input  logic ctl_ads_n,
  input  logic adv_n,
  output cmd_e cmd
);
  // Processor strobe wins over controller strobe; chip enable only matters
  // when some strobe is low.
  always_comb begin
    if (!cpu_ads_n)      cmd = ce_n ? CMD_DESEL : CMD_START_RD;
    else if (!ctl_ads_n) cmd = ce_n ? CMD_DESEL : CMD_START_CTL;
    else                 cmd = adv_n ? CMD_HOLD : CMD_STEP;
  end
endmodule

// File: rtl/bsram_addr.sv
module bsram_addr
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int LANES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [LANES-1:0]  wen_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rd_q
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic              active_q, active_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic              acc_valid, write_ok, rd_d, addr_en;

  always_comb begin
    active_d  = active_q;
    hi_d      = hi_q;
    cnt_d     = cnt_q;
    acc_valid = 1'b0;
    write_ok  = 1'b0;
    unique case (cmd)
      CMD_DESEL: active_d = 1'b0;
      CMD_START_RD, CMD_START_CTL: begin
        active_d  = 1'b1;
        hi_d      = addr_i[ADDR_W-1:BURST_W];
        cnt_d     = addr_i[BURST_W-1:0];
        acc_valid = 1'b1;
        write_ok  = (cmd == CMD_START_CTL);
      end
      CMD_STEP: begin
        acc_valid = active_q;
        write_ok  = 1'b1;
        if (active_q) cnt_d = cnt_q + 1'b1;
      end
      default: begin
        acc_valid = active_q;
        write_ok  = 1'b1;
      end
    endcase
  end

  assign addr_en  = (cnt_d != cnt_q) || (hi_d != hi_q);
  assign wr_lanes = (acc_valid && write_ok) ? ~wen_n : '0;
  assign rd_d     = acc_valid && (!write_ok || (&wen_n));
  assign acc_addr = {hi_d, cnt_d};
  assign cur_addr = {hi_q, cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      cnt_q <= '0;
    end else if (addr_en) begin
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  a_r5_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP && active_q) |=> cnt_q == BURST_W'($past(cnt_q) + 1'b1));
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP) |=> $stable(hi_q));
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> ($stable(cnt_q) && $stable(hi_q)));
  a_r2_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DESEL) |=> (!active_q && !rd_q));
  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && (cmd == CMD_STEP || cmd == CMD_HOLD)) |-> (wr_lanes == '0));
  a_r3_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_START_RD) |=> (cur_addr == $past(addr_i) && rd_q));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 9,
  parameter int LANE0_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_lanes,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LSB = (g == 0) ? 0 : LANE0_W;
    localparam int W   = (g == 0) ? LANE0_W : DATA_W - LANE0_W;
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) mem[waddr] <= wdata[LSB +: W];
    end

    assign rdata[LSB +: W] = mem[raddr];

    a_r7_lane_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lanes[g] |=> mem[$past(waddr)] == $past(wdata[LSB +: W]));
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 9,
  parameter int LANE0_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cpu_ads_n,
  input  logic              ctl_ads_n,
  input  logic              adv_n,
  input  logic [1:0]        wen_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  cmd_e              cmd;
  logic [ADDR_W-1:0] acc_addr, cur_addr;
  logic [1:0]        wr_lanes;
  logic              rd_q;

  bsram_decode u_dec (
    .ce_n(ce_n), .cpu_ads_n(cpu_ads_n), .ctl_ads_n(ctl_ads_n),
    .adv_n(adv_n), .cmd(cmd)
  );

  bsram_addr #(.ADDR_W(ADDR_W), .BURST_W(2), .LANES(2)) u_addr (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wen_n(wen_n), .addr_i(addr),
    .acc_addr(acc_addr), .wr_lanes(wr_lanes), .cur_addr(cur_addr), .rd_q(rd_q)
  );

  bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE0_W(LANE0_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_lanes(wr_lanes), .waddr(acc_addr),
    .wdata(dq_in), .raddr(cur_addr), .rdata(dq_out)
  );

  assign dq_oe = rd_q && !oe_n;

  a_r8_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_lanes) |=> !dq_oe);
  a_r4_ctl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_START_CTL && wen_n == 2'b11 && !oe_n) |=> (dq_oe || oe_n));
endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, cpu_ads_n, ctl_ads_n, adv_n, oe_n;
  logic [1:0] wen_n;
  logic [5:0] addr;
  logic [8:0] dq_in, dq_out;
  logic       dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit         drv;
    logic [8:0] data;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  burst_sram dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cpu_ads_n(cpu_ads_n),
    .ctl_ads_n(ctl_ads_n), .adv_n(adv_n), .wen_n(wen_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic step(input logic ce, input logic cpu, input logic ctl,
                      input logic adv, input logic [1:0] we, input logic [5:0] a,
                      input logic [8:0] d, input logic oe, input bit drv,
                      input logic [8:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    ce_n = ce; cpu_ads_n = cpu; ctl_ads_n = ctl; adv_n = adv;
    wen_n = we; addr = a; dq_in = d; oe_n = oe;
    it.drv = drv; it.data = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare after each edge
  always begin
    item_t it;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (dq_oe !== it.drv || (it.drv && dq_out !== it.data)) begin
        errors++;
        $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                 it.tag, dq_oe, dq_out, it.drv, it.data);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; cpu_ads_n = 1'b1; ctl_ads_n = 1'b1;
    adv_n = 1'b1; wen_n = 2'b11; oe_n = 1'b0; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: oe=%b expected oe=0", dq_oe);
    end
    // R1: suspend cycle right after reset performs no access
    step(0,1,1,1,2'b11,6'h00,9'h000,0, 0,9'h000, "R1 idle after reset");
    // R4 R9: controller write burst at 0x08, suspend wait state mid-burst
    step(0,1,0,1,2'b00,6'h08,9'h101,0, 0,9'h000, "R4 ctl write start");
    step(0,1,1,0,2'b00,6'h3F,9'h0A2,0, 0,9'h000, "R5 advance write");
    step(0,1,1,1,2'b11,6'h3F,9'h1FF,0, 1,9'h0A2, "R6 suspend read same word");
    step(0,1,1,0,2'b00,6'h3F,9'h133,0, 0,9'h000, "R9 advance write");
    step(0,1,1,0,2'b00,6'h3F,9'h044,0, 0,9'h000, "R9 advance write last");
    // R3: processor start with write enables active still reads
    step(0,0,0,1,2'b00,6'h0A,9'h1FF,0, 1,9'h133, "R3 cpu start reads");
    step(0,1,1,0,2'b11,6'h3F,9'h000,0, 1,9'h044, "R5 advance read");
    step(0,1,1,0,2'b11,6'h3F,9'h000,0, 1,9'h101, "R5 wrap 3 to 0");
    step(0,1,1,0,2'b11,6'h3F,9'h000,0, 1,9'h0A2, "R5 after wrap");
    step(0,1,1,1,2'b11,6'h3F,9'h000,1, 0,9'h000, "R8 oe_n high hides read");
    step(0,1,0,1,2'b11,6'h0A,9'h000,0, 1,9'h133, "R4 ctl read, R3 no write");
    // R7: lane writes
    step(0,1,0,1,2'b10,6'h0B,9'h1E5,0, 0,9'h000, "R7 lower lane write");
    step(0,1,1,1,2'b11,6'h00,9'h000,0, 1,9'h045, "R7 lower lane only");
    step(0,1,0,1,2'b01,6'h0B,9'h1E0,0, 0,9'h000, "R7 upper lane write");
    step(0,1,1,1,2'b11,6'h00,9'h000,0, 1,9'h1E5, "R7 upper lane only");
    // R2: deselect, then advance/suspend with writes must do nothing
    step(1,0,1,1,2'b11,6'h00,9'h000,0, 0,9'h000, "R2 desel by cpu strobe");
    step(0,1,1,0,2'b00,6'h00,9'h000,0, 0,9'h000, "R2 advance while desel");
    step(0,1,1,1,2'b00,6'h00,9'h000,0, 0,9'h000, "R2 suspend while desel");
    step(0,0,1,1,2'b11,6'h0B,9'h000,0, 1,9'h1E5, "R2 word kept");
    step(1,1,0,1,2'b11,6'h00,9'h000,0, 0,9'h000, "R2 desel by ctl strobe");
    step(0,0,1,1,2'b11,6'h08,9'h000,0, 1,9'h101, "R2 next word kept");
    // R5: chip enable ignored while advancing
    step(1,1,1,0,2'b11,6'h00,9'h000,0, 1,9'h0A2, "R5 ce_n ignored");
    step(0,1,1,1,2'b11,6'h00,9'h000,0, 1,9'h0A2, "R8 flow-through hold");
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule